// File: doc/BRIEF.md
# Endpoint Handshake and Data Toggle Controller

This block holds the control state of one endpoint in a USB device controller. It stores the endpoint enable, a pending STALL flag and the DATA0/DATA1 toggle. Firmware reaches it through a byte-wide register write port with a combinational read-back. The packet engine sends single-cycle strobes for three events: a SETUP packet arrived, an IN packet was acknowledged by the host, and an OUT packet arrived.

From this state the block drives two results. The first is the handshake the packet engine should return: nothing, ACK or STALL. The second is the data PID to send on IN or to expect on OUT. For an OUT packet it also says whether the payload should be kept, which is the case when the PID matches the expected toggle. Three write-one strobe bits act on the state: one arms STALL, one disarms it, and one forces the toggle back to DATA0. None of them is stored as a readable bit. The state of the pending STALL is brought out on its own status pin.

Top module: `ep_hs_ctrl`

## Requirements
- R1: After `rst_n` is released, the enable is 1 when parameter `EP_INDEX` is 0 and 0 otherwise, no STALL is pending, and the toggle is DATA0 (`data_pid1` = 0).
- R2: `reg_rdata` bit 0 shows the enable and bits 7..1 always read 0, including the strobe positions. A write stores `reg_wdata` bit 0 into the enable from the next cycle.
- R3: A write with bit 5 = 1 sets `stall_pending` from the next cycle. A write with bit 5 = 0 leaves it unchanged.
- R4: A write with bit 4 = 1 clears `stall_pending` from the next cycle. This holds even when bit 5 is also 1 in the same write.
- R5: `evt_setup` on an enabled endpoint clears `stall_pending` and sets the toggle to DATA1 from the next cycle. It wins over a stall-request write and over a reset-toggle write in the same cycle.
- R6: A write with bit 3 = 1 makes the toggle DATA0 from the next cycle, whether or not the endpoint is enabled. A write with bit 3 = 0 leaves the toggle unchanged.
- R7: With `ep_is_in` = 1 on an enabled endpoint, `evt_in_ack` inverts the toggle and `evt_out_ok` leaves it unchanged.
- R8: With `ep_is_in` = 0 on an enabled endpoint, `evt_out_ok` whose `out_pid_data1` equals `data_pid1` drives `out_keep` = 1 in that cycle and inverts the toggle. A mismatched PID gives `out_keep` = 0 and leaves the toggle unchanged. `evt_in_ack` is ignored.
- R9: `hs_code` reflects the current state combinationally: 2'b00 (none) while disabled, 2'b10 (STALL) while enabled with a STALL pending, and 2'b01 (ACK) otherwise.
- R10: While the endpoint is disabled, `evt_setup`, `evt_in_ack` and `evt_out_ok` change neither the STALL flag nor the toggle, and `out_keep` stays 0.
- R11: `bus_reset` returns the enable to its R1 value, clears the STALL flag and sets DATA0 from the next cycle. It overrides a register write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | USB bus reset strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data: bit 5 stall request, bit 4 stall clear, bit 3 toggle reset, bit 0 enable |
| reg_rdata | output | 8 | Read data: enable in bit 0, zeros elsewhere |
| ep_is_in | input | 1 | Endpoint direction, 1 = IN |
| evt_setup | input | 1 | SETUP packet received |
| evt_in_ack | input | 1 | IN packet acknowledged by host |
| evt_out_ok | input | 1 | OUT packet received without error |
| out_pid_data1 | input | 1 | PID of the received OUT packet, 1 = DATA1 |
| hs_code | output | 2 | Handshake to return: 00 none, 01 ACK, 10 STALL |
| data_pid1 | output | 1 | Current toggle, 1 = DATA1 |
| stall_pending | output | 1 | STALL armed |
| out_keep | output | 1 | Received OUT payload matches the toggle and is kept |

## Verification
A wrong enable, STALL flag or toggle shows up at the ports in the same cycle it exists. `reg_rdata`, `hs_code`, `data_pid1` and `stall_pending` are decoded directly from state, so a bad update on one edge is visible one cycle after the triggering strobe. A mistaken toggle flip also corrupts `out_keep` on every later OUT packet. The reference model is compared on every clock, so the first divergent cycle is reported, including the priority collisions between SETUP, bus reset and the write strobes.

// File: rtl/ep_hs_pkg.sv
// Package: shared constants and types for the endpoint handshake controller.
// Assumes an 8-bit control register whose strobe positions are fixed.
package ep_hs_pkg;
    localparam int REG_W      = 8;
    localparam int POS_EN     = 0;
    localparam int POS_TOGRST = 3;
    localparam int POS_STCLR  = 4;
    localparam int POS_STREQ  = 5;
    localparam int HS_W       = 2;

    typedef enum logic [HS_W-1:0] {
        HS_NONE  = 2'b00,
        HS_ACK   = 2'b01,
        HS_STALL = 2'b10
    } hs_e;
endpackage

// File: rtl/ep_cfg_reg.sv
// Module: enable and STALL flag storage with write-strobe decoding.
// Assumes the caller gates SETUP with the current enable (setup_hit).
module ep_cfg_reg
    import ep_hs_pkg::*;
#(
    parameter logic EN_RST = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_reset,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             setup_hit,
    output logic             en_q,
    output logic             stall_q,
    output logic             tog_clr_stb
);
    logic stall_set;
    logic stall_clr;
    logic unused_wbits;

    // Decode the write-one strobes; none of them is stored
    always_comb begin
        stall_set   = reg_wr && reg_wdata[POS_STREQ];
        stall_clr   = (reg_wr && reg_wdata[POS_STCLR]) || setup_hit;
        tog_clr_stb = reg_wr && reg_wdata[POS_TOGRST];
    end

    assign unused_wbits = ^{reg_wdata[REG_W-1:POS_STREQ+1], reg_wdata[POS_TOGRST-1:POS_EN+1]};

    // Enable register: reset and bus reset restore the per-endpoint default
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= EN_RST;
        end else if (bus_reset) begin
            en_q <= EN_RST;
        end else if (reg_wr) begin
            en_q <= reg_wdata[POS_EN];
        end
    end

    // STALL flag: clear (write or SETUP) wins over set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_q <= 1'b0;
        end else if (bus_reset || stall_clr) begin
            stall_q <= 1'b0;
        end else if (stall_set) begin
            stall_q <= 1'b1;
        end
    end
endmodule

// File: rtl/ep_toggle_seq.sv
// Module: DATA0/DATA1 toggle sequencer.
// Assumes the event inputs are already qualified by enable and direction.
module ep_toggle_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset,
    input  logic setup_hit,
    input  logic tog_clr_stb,
    input  logic in_done,
    input  logic out_match,
    output logic tog_q
);
    // Toggle state: SETUP > forced clear > successful transfer flip
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else if (bus_reset) begin
            tog_q <= 1'b0;
        end else if (setup_hit) begin
            tog_q <= 1'b1;
        end else if (tog_clr_stb) begin
            tog_q <= 1'b0;
        end else if (in_done || out_match) begin
            tog_q <= ~tog_q;
        end
    end
endmodule

// File: rtl/ep_hs_resp.sv
// Module: combinational handshake selection and OUT PID match.
// Assumes state inputs come straight from registers.
module ep_hs_resp
    import ep_hs_pkg::*;
(
    input  logic            en_q,
    input  logic            stall_q,
    input  logic            tog_q,
    input  logic            ep_is_in,
    input  logic            evt_in_ack,
    input  logic            evt_out_ok,
    input  logic            out_pid_data1,
    output logic [HS_W-1:0] hs_code,
    output logic            in_done,
    output logic            out_match
);
    hs_e hs_sel;

    // Pick the handshake from enable and STALL state
    always_comb begin
        if (!en_q) begin
            hs_sel = HS_NONE;
        end else if (stall_q) begin
            hs_sel = HS_STALL;
        end else begin
            hs_sel = HS_ACK;
        end
    end

    assign hs_code = hs_sel;

    // Qualify transfer events by enable, direction and PID match
    always_comb begin
        in_done   = en_q && ep_is_in && evt_in_ack;
        out_match = en_q && !ep_is_in && evt_out_ok && (out_pid_data1 == tog_q);
    end
endmodule

// File: rtl/ep_hs_ctrl.sv
// Module: top of the per-endpoint handshake controller.
// Assumes one event strobe per packet and single-cycle register writes.
module ep_hs_ctrl
    import ep_hs_pkg::*;
#(
    parameter int EP_INDEX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_reset,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             ep_is_in,
    input  logic             evt_setup,
    input  logic             evt_in_ack,
    input  logic             evt_out_ok,
    input  logic             out_pid_data1,
    output logic [HS_W-1:0]  hs_code,
    output logic             data_pid1,
    output logic             stall_pending,
    output logic             out_keep
);
    localparam logic EN_RST = (EP_INDEX == 0);

    logic en_q;
    logic stall_q;
    logic tog_q;
    logic tog_clr_stb;
    logic setup_hit;
    logic in_done;
    logic out_match;

    // SETUP acts only on an enabled endpoint
    assign setup_hit = en_q && evt_setup;

    ep_cfg_reg #(.EN_RST(EN_RST)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_reset   (bus_reset),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .setup_hit   (setup_hit),
        .en_q        (en_q),
        .stall_q     (stall_q),
        .tog_clr_stb (tog_clr_stb)
    );

    ep_toggle_seq u_tog (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_reset   (bus_reset),
        .setup_hit   (setup_hit),
        .tog_clr_stb (tog_clr_stb),
        .in_done     (in_done),
        .out_match   (out_match),
        .tog_q       (tog_q)
    );

    ep_hs_resp u_resp (
        .en_q          (en_q),
        .stall_q       (stall_q),
        .tog_q         (tog_q),
        .ep_is_in      (ep_is_in),
        .evt_in_ack    (evt_in_ack),
        .evt_out_ok    (evt_out_ok),
        .out_pid_data1 (out_pid_data1),
        .hs_code       (hs_code),
        .in_done       (in_done),
        .out_match     (out_match)
    );

    // Read-back: only the enable is visible; strobe bits read 0
    always_comb begin
        reg_rdata         = '0;
        reg_rdata[POS_EN] = en_q;
    end

    assign data_pid1     = tog_q;
    assign stall_pending = stall_q;
    assign out_keep      = out_match;
endmodule

// File: rtl/ep_hs_ctrl_chk.sv
// Module: property checker for ep_hs_ctrl, attached by bind.
// Assumes the default register layout from ep_hs_pkg.
module ep_hs_ctrl_chk
    import ep_hs_pkg::*;
#(
    parameter int EP_INDEX = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_reset,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             ep_is_in,
    input logic             evt_setup,
    input logic             evt_in_ack,
    input logic             evt_out_ok,
    input logic             out_pid_data1,
    input logic [HS_W-1:0]  hs_code,
    input logic             data_pid1,
    input logic             stall_pending,
    input logic             out_keep
);
    localparam logic EN_RST = (EP_INDEX == 0);

    // R2
    rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:1] == '0);

    // R3
    stall_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[POS_STREQ] && !reg_wdata[POS_STCLR]
         && !(reg_rdata[POS_EN] && evt_setup) && !bus_reset) |=> stall_pending);

    // R4
    stall_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[POS_STCLR]) |=> !stall_pending);

    // R5
    setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[POS_EN] && evt_setup && !bus_reset) |=> (!stall_pending && data_pid1));

    // R6
    togrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[POS_TOGRST] && !(reg_rdata[POS_EN] && evt_setup)) |=> !data_pid1);

    // R8
    keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_keep |-> (evt_out_ok && !ep_is_in && (out_pid_data1 == data_pid1)));

    // R8
    mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[POS_EN] && !ep_is_in && evt_out_ok && (out_pid_data1 != data_pid1)
         && !evt_setup && !reg_wr && !bus_reset) |=> $stable(data_pid1));

    // R9
    hs_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[POS_EN] && stall_pending) |-> (hs_code == HS_STALL));

    // R10
    disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[POS_EN] && !reg_wr && !bus_reset)
        |=> ($stable(data_pid1) && $stable(stall_pending)));

    // R10
    disabled_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[POS_EN] |-> (hs_code == HS_NONE && !out_keep));

    // R11
    busrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (reg_rdata[POS_EN] == EN_RST && !stall_pending && !data_pid1));

    // R7
    in_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[POS_EN] && ep_is_in && evt_in_ack && !evt_setup && !reg_wr && !bus_reset)
        |=> (data_pid1 != $past(data_pid1)));

    logic unused_chk;
    assign unused_chk = ^{evt_out_ok, out_pid_data1};
endmodule

bind ep_hs_ctrl ep_hs_ctrl_chk #(.EP_INDEX(EP_INDEX)) u_chk (.*);

// File: tb/sim_ep_hs_ctrl.sv
`timescale 1ns/1ps
module sim_ep_hs_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_reset = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       ep_is_in = 1'b0;
    logic       evt_setup = 1'b0;
    logic       evt_in_ack = 1'b0;
    logic       evt_out_ok = 1'b0;
    logic       out_pid_data1 = 1'b0;
    logic [1:0] hs_code;
    logic       data_pid1;
    logic       stall_pending;
    logic       out_keep;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural model state
    int m_en, m_stall, m_tog;

    always #2.5 clk = ~clk;

    ep_hs_ctrl #(.EP_INDEX(0)) u0 (.*);

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic idle();
        bus_reset = 0; reg_wr = 0; reg_wdata = 0;
        evt_setup = 0; evt_in_ack = 0; evt_out_ok = 0; out_pid_data1 = 0;
    endtask

    // compare now, then advance one clock and update the model
    task automatic cyc(string tag);
        int act_en, e_hs, e_keep;
        #1;
        e_hs   = (m_en == 0) ? 0 : (m_stall != 0) ? 2 : 1;
        e_keep = (m_en != 0 && !ep_is_in && evt_out_ok && (int'(out_pid_data1) == m_tog)) ? 1 : 0;
        chk(tag, "rdata", int'(reg_rdata), m_en);
        chk(tag, "hs_code", int'(hs_code), e_hs);
        chk(tag, "data_pid1", int'(data_pid1), m_tog);
        chk(tag, "stall_pending", int'(stall_pending), m_stall);
        chk(tag, "out_keep", int'(out_keep), e_keep);
        @(posedge clk);
        act_en = m_en;
        if (bus_reset) begin
            m_en = 1; m_stall = 0; m_tog = 0;
        end else begin
            if (reg_wr) m_en = int'(reg_wdata[0]);
            if (reg_wr && reg_wdata[5]) m_stall = 1;
            if ((act_en != 0 && evt_setup) || (reg_wr && reg_wdata[4])) m_stall = 0;
            if (act_en != 0 && evt_setup) m_tog = 1;
            else if (reg_wr && reg_wdata[3]) m_tog = 0;
            else if (act_en != 0 && ep_is_in && evt_in_ack) m_tog ^= 1;
            else if (act_en != 0 && !ep_is_in && evt_out_ok && int'(out_pid_data1) == m_tog) m_tog ^= 1;
        end
        @(negedge clk);
        idle();
    endtask

    task automatic wr(logic [7:0] d, string tag);
        reg_wr = 1; reg_wdata = d; cyc(tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_en = 1; m_stall = 0; m_tog = 0;
        cyc("R1");                       // reset state: enabled EP0, DATA0
        cyc("R9");                       // ACK while enabled, no stall
        wr(8'h20 | 8'h01, "R3");         // arm stall
        cyc("R3");
        wr(8'h01, "R3");                 // bit5 = 0: stall stays
        cyc("R9");                       // STALL handshake
        wr(8'h31, "R4");                 // req + clr together: clear wins
        cyc("R4");
        wr(8'hC7, "R2");                 // reserved bits set, enable kept
        cyc("R2");
        wr(8'h21, "R5");
        evt_setup = 1; reg_wr = 1; reg_wdata = 8'h29; cyc("R5"); // SETUP beats req and toggle reset
        cyc("R5");
        wr(8'h09, "R6");                 // toggle back to DATA0
        cyc("R6");
        ep_is_in = 1;
        evt_in_ack = 1; cyc("R7");
        evt_in_ack = 1; cyc("R7");
        evt_out_ok = 1; out_pid_data1 = 0; cyc("R7");
        ep_is_in = 0;
        evt_out_ok = 1; out_pid_data1 = 0; cyc("R8"); // match
        evt_out_ok = 1; out_pid_data1 = 0; cyc("R8"); // mismatch
        evt_out_ok = 1; out_pid_data1 = 1; cyc("R8"); // match
        evt_in_ack = 1; cyc("R8");                    // ignored on OUT
        wr(8'h21, "R6");                 // bit3 = 0: toggle unchanged
        wr(8'h00, "R2");                 // disable
        cyc("R9");
        evt_setup = 1; cyc("R10");
        evt_out_ok = 1; out_pid_data1 = 0; cyc("R10");
        ep_is_in = 1; evt_in_ack = 1; cyc("R10");
        ep_is_in = 0;
        wr(8'h08, "R6");                 // toggle reset works while disabled
        cyc("R10");
        wr(8'h21, "R2");
        evt_setup = 1; cyc("R5");
        bus_reset = 1; reg_wr = 1; reg_wdata = 8'h20; cyc("R11");
        cyc("R11");
        for (int i = 0; i < 600; i++) begin
            int r = int'($urandom_range(0, 99));
            ep_is_in      = $urandom_range(0, 1);
            out_pid_data1 = $urandom_range(0, 1);
            evt_setup     = (r < 8);
            evt_in_ack    = (r >= 8 && r < 35);
            evt_out_ok    = (r >= 35 && r < 60);
            reg_wr        = (r >= 60 && r < 80);
            reg_wdata     = 8'($urandom_range(0, 255)) | ((r < 75) ? 8'h01 : 8'h00);
            bus_reset     = (r == 99);
            cyc("R7/R8/R10 mix");
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule